// File: doc/BRIEF.md
# Serial Configuration and Colour Table Port

A three-wire serial slave (active-low select, serial clock, one shared data line) through which a host programs a handful of configuration bits and fills three 256-entry, 8-bit colour correction tables, one per primary. The same tables sit in the pixel path: when table use is enabled, each incoming 8-bit red, green and blue component is replaced by the table entry it addresses, one clock later.

The serial pins are oversampled in the core clock domain. Each transfer is a header byte (direction bit, then a 7-bit address, MSB first) followed by data bytes, MSB first, taken on the rising serial clock. The port stays locked after reset and after power-down, so it can share the bus with a second slave. It opens only after the all-ones key is written to the lock register. Table entries go through an index register and three per-colour data windows. Streamed writes into a window advance the index and wrap it within the table.

Top module: `spi_lut_port`

## Requirements
- R1: A transfer starts with a direction bit (1 read, 0 write), then seven address bits MSB first, then eight data bits MSB first, each bit taken on a rising edge of `spi_sck` while `spi_cs_n` is low.
- R2: After reset or power-down the port is locked. A write of 0xFF to address 0x16 unlocks it and a write of any other value there locks it. While locked, every other write is ignored and reads leave the data line undriven.
- R3: `spi_sdo_en` is high only during the eight data bits of a read to an unlocked port, with `spi_sdo` presenting the data MSB first. The host samples each bit at the rising serial clock edge.
- R4: Address 0x00 is the control register. Bit 0 enables table access and table use in the pixel path (`cfg_lut_en`), bit 1 drives `cfg_dither_en`, bit 4 opens the lane register, and all other bits read back as zero.
- R5: Address 0x0A is the lane register. Bit 2 set selects three lanes (`cfg_lane3`), other bits read as zero, and a write is honoured only while control bit 4 is set.
- R6: The lock register 0x16 is write-only and reads return 0x00.
- R7: Address 0x20 is the table index. Addresses 0x40, 0x41 and 0x42 are the red, green and blue data windows. A window write stores at the index and advances it by one modulo 256, and a window read returns the entry at the index. With control bit 0 clear, window writes are ignored and window reads return 0x00.
- R8: While select stays low, further data bytes stream in. Outside the windows each byte goes to the next address. At most 256 data bytes are accepted per transfer and later bytes are ignored.
- R9: Select rising in mid-byte discards the partial byte, and the next transfer starts again at the direction bit.
- R10: The port responds only while `spi_cs_n` is low, `pwr_on` is high and `pclk_quiet` is high.
- R11: `pwr_on` low clears every register and the lock but keeps the table contents.
- R12: One cycle after `pix_vld`, `out_vld` is high and each output component is the table entry for that input if `cfg_lut_en` is set, or the input unchanged otherwise.
- R13: A pixel lookup in the same cycle as a serial write to the entry it addresses returns the old entry, and the next lookup returns the new one.
- R14: After reset, two lanes, dither off and table off are selected, and `spi_sdo_en` and `out_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, also used to oversample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_on | input | 1 | High for normal operation, low for power-down |
| pclk_quiet | input | 1 | High while the pixel clock is held static |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_sdi | input | 1 | Data line value seen at the pin |
| spi_sdo | output | 1 | Data line value driven during reads |
| spi_sdo_en | output | 1 | Output enable for the shared data line |
| pix_vld | input | 1 | Input pixel valid |
| pix_r | input | 8 | Input red component |
| pix_g | input | 8 | Input green component |
| pix_b | input | 8 | Input blue component |
| out_vld | output | 1 | Output pixel valid |
| out_r | output | 8 | Output red component |
| out_g | output | 8 | Output green component |
| out_b | output | 8 | Output blue component |
| cfg_lut_en | output | 1 | Table use enabled |
| cfg_dither_en | output | 1 | Dither enable for the downstream stage |
| cfg_lane3 | output | 1 | Three-lane mode selected |

## Verification
A serial write that commits a table entry and a pixel lookup of that same entry can land on one clock edge. The bench holds a pixel valid on one red value and overwrites that entry over the serial port while watching every output cycle. It judges the stream by three rules: only the old or new value may appear, the old value may never return once the new one has shown, and the stream must end on the new value. The tables themselves are swept exhaustively, with all 256 input codes per colour checked against tables the bench fills from arithmetic patterns, including page writes that wrap past the top of the index.

// File: rtl/spi_lut_pkg.sv
// Shared constants, address map and decoder state type for the serial
// configuration and colour table port. Assumes a 7-bit register address
// space and 8-bit data bytes.
package spi_lut_pkg;
    localparam int ADDR_W    = 7;
    localparam int BYTE_W    = 8;
    localparam int LUT_DEPTH = 256;
    localparam int IDX_W     = $clog2(LUT_DEPTH);
    localparam int NUM_CH    = 3;
    localparam int PAGE_MAX  = 256;
    localparam int SYNC_STG  = 2;

    localparam logic [ADDR_W-1:0] A_CTRL  = 7'h00;
    localparam logic [ADDR_W-1:0] A_LANE  = 7'h0A;
    localparam logic [ADDR_W-1:0] A_LOCK  = 7'h16;
    localparam logic [ADDR_W-1:0] A_INDEX = 7'h20;
    localparam logic [ADDR_W-1:0] A_WIN0  = 7'h40;

    localparam logic [BYTE_W-1:0] OPEN_KEY  = 8'hFF;
    localparam logic [BYTE_W-1:0] CTRL_MASK = 8'h13;
    localparam logic [BYTE_W-1:0] LANE_MASK = 8'h04;

    localparam int CTRL_TBL_BIT  = 0;
    localparam int CTRL_DITH_BIT = 1;
    localparam int CTRL_SPEC_BIT = 4;
    localparam int LANE_3_BIT    = 2;

    typedef enum logic [1:0] {
        DS_HDR   = 2'd0,
        DS_WDATA = 2'd1,
        DS_RDATA = 2'd2,
        DS_IDLE  = 2'd3
    } dec_state_t;

    // True when an address falls inside one of the per-colour windows.
    function automatic logic in_window(logic [ADDR_W-1:0] a);
        return (a >= A_WIN0) && (a < A_WIN0 + ADDR_W'(NUM_CH));
    endfunction

    // Colour channel selected by a window address.
    function automatic logic [1:0] window_ch(logic [ADDR_W-1:0] a);
        return 2'(a - A_WIN0);
    endfunction
endpackage

// File: rtl/spi_lut_sync.sv
// Oversamples the three serial pins into the core clock domain.
// Assumes the core clock runs at least four times faster than the serial
// clock. Select, clock and data pass through chains of equal depth so that
// the data bit stays aligned with the detected clock edge.
module spi_lut_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_raw,
    input  logic sck_raw,
    input  logic sdi_raw,
    output logic cs_n_s,
    output logic sdi_s,
    output logic sck_rise
);
    localparam logic [2:0] IDLE_PINS = 3'b100;

    logic [2:0] stg [STAGES];
    logic       sck_d;

    // Shift the pin triple through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= IDLE_PINS;
        end else begin
            stg[0] <= {cs_n_raw, sck_raw, sdi_raw};
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    // Delay the synchronised clock by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= stg[STAGES-1][1];
    end

    assign cs_n_s   = stg[STAGES-1][2];
    assign sdi_s    = stg[STAGES-1][0];
    assign sck_rise = stg[STAGES-1][1] & ~sck_d;
endmodule

// File: rtl/spi_lut_decoder.sv
// Frame decoder: collects the header byte, then either streams write bytes
// out as strobes or shifts one read byte onto the data line. Assumes the
// register file answers a read address combinationally in the same cycle.
// Leaving the active condition discards any partial byte.
module spi_lut_decoder
    import spi_lut_pkg::*;
#(
    parameter int A_W      = ADDR_W,
    parameter int D_W      = BYTE_W,
    parameter int PAGE_LIM = PAGE_MAX
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           active,
    input  logic           sck_rise,
    input  logic           sdi,
    input  logic           unlocked,
    input  logic [D_W-1:0] rd_data,
    output logic [A_W-1:0] rd_addr,
    output logic           wr_stb,
    output logic [A_W-1:0] wr_addr,
    output logic [D_W-1:0] wr_data,
    output logic           sdo,
    output logic           sdo_en
);
    localparam int CNT_W = $clog2(D_W);
    localparam int PG_W  = $clog2(PAGE_LIM + 1);

    dec_state_t     state;
    logic [CNT_W-1:0] bit_cnt;
    logic [D_W-1:0] rx_sh;
    logic [D_W-1:0] tx_sh;
    logic [A_W-1:0] addr_q;
    logic [PG_W-1:0] pg_cnt;
    logic [D_W-1:0] nxt_byte;
    logic           byte_end;

    assign nxt_byte = {rx_sh[D_W-2:0], sdi};
    assign byte_end = (bit_cnt == CNT_W'(D_W - 1));
    assign rd_addr  = (state == DS_HDR) ? nxt_byte[A_W-1:0] : addr_q;
    assign sdo      = tx_sh[D_W-1];

    // Advance the frame state machine on each detected serial clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            state   <= DS_HDR;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            addr_q  <= '0;
            pg_cnt  <= '0;
            sdo_en  <= 1'b0;
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (sck_rise) begin
                rx_sh   <= nxt_byte;
                bit_cnt <= byte_end ? '0 : bit_cnt + 1'b1;
                case (state)
                    DS_HDR: begin
                        if (byte_end) begin
                            addr_q <= nxt_byte[A_W-1:0];
                            pg_cnt <= '0;
                            if (nxt_byte[D_W-1]) begin
                                if (unlocked) begin
                                    tx_sh  <= rd_data;
                                    sdo_en <= 1'b1;
                                    state  <= DS_RDATA;
                                end else begin
                                    state  <= DS_IDLE;
                                end
                            end else begin
                                state <= DS_WDATA;
                            end
                        end
                    end
                    DS_WDATA: begin
                        if (byte_end) begin
                            wr_stb  <= 1'b1;
                            wr_addr <= addr_q;
                            wr_data <= nxt_byte;
                            if (!in_window(addr_q)) addr_q <= addr_q + 1'b1;
                            pg_cnt  <= pg_cnt + 1'b1;
                            if (pg_cnt == PG_W'(PAGE_LIM - 1)) state <= DS_IDLE;
                        end
                    end
                    DS_RDATA: begin
                        if (byte_end) begin
                            sdo_en <= 1'b0;
                            state  <= DS_IDLE;
                        end else begin
                            tx_sh <= {tx_sh[D_W-2:0], 1'b0};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_lut_regs.sv
// Register file: lock key, control, lane and table index registers, the
// read-back multiplexer, and the write enables for the colour tables.
// Assumes write strobes last one cycle. Power-down clears all state here;
// table contents live elsewhere and are untouched.
module spi_lut_regs
    import spi_lut_pkg::*;
#(
    parameter int A_W  = ADDR_W,
    parameter int D_W  = BYTE_W,
    parameter int I_W  = IDX_W,
    parameter int N_CH = NUM_CH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pwr_on,
    input  logic                     wr_stb,
    input  logic [A_W-1:0]           wr_addr,
    input  logic [D_W-1:0]           wr_data,
    input  logic [A_W-1:0]           rd_addr,
    input  logic [N_CH-1:0][D_W-1:0] tbl_rd,
    output logic [D_W-1:0]           rd_data,
    output logic                     unlocked,
    output logic [N_CH-1:0]          tbl_we,
    output logic [I_W-1:0]           tbl_idx,
    output logic [D_W-1:0]           tbl_wdata,
    output logic                     cfg_lut_en,
    output logic                     cfg_dither_en,
    output logic                     cfg_lane3
);
    logic           clear;
    logic [D_W-1:0] ctrl_q;
    logic [D_W-1:0] lane_q;
    logic [I_W-1:0] idx_q;
    logic           open_q;
    logic           win_wr;

    assign clear     = !rst_n || !pwr_on;
    assign win_wr    = wr_stb && open_q && ctrl_q[CTRL_TBL_BIT] && in_window(wr_addr);
    assign tbl_idx   = idx_q;
    assign tbl_wdata = wr_data;

    // One write enable per colour window.
    for (genvar c = 0; c < N_CH; c++) begin : g_we
        assign tbl_we[c] = win_wr && (window_ch(wr_addr) == 2'(c));
    end

    // Apply honoured writes; the lock register is reachable even when locked.
    always_ff @(posedge clk) begin
        if (clear) begin
            ctrl_q <= '0;
            lane_q <= '0;
            idx_q  <= '0;
            open_q <= 1'b0;
        end else if (wr_stb) begin
            if (wr_addr == A_LOCK) begin
                open_q <= (wr_data == OPEN_KEY);
            end else if (open_q) begin
                if (wr_addr == A_CTRL) ctrl_q <= wr_data & CTRL_MASK;
                if (wr_addr == A_LANE && ctrl_q[CTRL_SPEC_BIT]) lane_q <= wr_data & LANE_MASK;
                if (wr_addr == A_INDEX) idx_q <= I_W'(wr_data);
                if (win_wr) idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Read-back multiplexer; unknown and write-only addresses return zero.
    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL)       rd_data = ctrl_q;
        else if (rd_addr == A_LANE)  rd_data = lane_q;
        else if (rd_addr == A_INDEX) rd_data = D_W'(idx_q);
        else if (in_window(rd_addr) && ctrl_q[CTRL_TBL_BIT])
            rd_data = tbl_rd[window_ch(rd_addr)];
    end

    assign unlocked      = open_q;
    assign cfg_lut_en    = ctrl_q[CTRL_TBL_BIT];
    assign cfg_dither_en = ctrl_q[CTRL_DITH_BIT];
    assign cfg_lane3     = lane_q[LANE_3_BIT];
endmodule

// File: rtl/spi_lut_tables.sv
// Three colour tables with one write port, an unregistered read port for
// the serial side and a registered lookup port for the pixel path. Table
// storage has no reset so its contents survive power-down. A lookup and a
// write to the same entry in one cycle return the old entry.
module spi_lut_tables
    import spi_lut_pkg::*;
#(
    parameter int D_W   = BYTE_W,
    parameter int DEPTH = LUT_DEPTH,
    parameter int I_W   = IDX_W,
    parameter int N_CH  = NUM_CH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_CH-1:0]          we,
    input  logic [I_W-1:0]           idx,
    input  logic [D_W-1:0]           wdata,
    output logic [N_CH-1:0][D_W-1:0] spi_rd,
    input  logic                     lut_en,
    input  logic                     pix_vld,
    input  logic [N_CH-1:0][D_W-1:0] pix_in,
    output logic                     out_vld,
    output logic [N_CH-1:0][D_W-1:0] pix_out
);
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [D_W-1:0] tbl [DEPTH];
        logic [D_W-1:0] px_q;

        // Store a serial write into this colour's table.
        always_ff @(posedge clk) begin
            if (we[c]) tbl[idx] <= wdata;
        end

        // Map or pass through this colour component for one valid pixel.
        always_ff @(posedge clk) begin
            if (!rst_n)       px_q <= '0;
            else if (pix_vld) px_q <= lut_en ? tbl[I_W'(pix_in[c])] : pix_in[c];
        end

        assign spi_rd[c]  = tbl[idx];
        assign pix_out[c] = px_q;
    end

    // Output valid follows input valid by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_vld <= 1'b0;
        else        out_vld <= pix_vld;
    end
endmodule

// File: rtl/spi_lut_port.sv
// Top level of the serial configuration and colour table port. Joins the
// pin synchroniser, frame decoder, register file and colour tables.
// Assumes the core clock oversamples the serial clock at least four times.
module spi_lut_port
    import spi_lut_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_on,
    input  logic       pclk_quiet,
    input  logic       spi_cs_n,
    input  logic       spi_sck,
    input  logic       spi_sdi,
    output logic       spi_sdo,
    output logic       spi_sdo_en,
    input  logic       pix_vld,
    input  logic [7:0] pix_r,
    input  logic [7:0] pix_g,
    input  logic [7:0] pix_b,
    output logic       out_vld,
    output logic [7:0] out_r,
    output logic [7:0] out_g,
    output logic [7:0] out_b,
    output logic       cfg_lut_en,
    output logic       cfg_dither_en,
    output logic       cfg_lane3
);
    logic                       cs_n_s;
    logic                       sdi_s;
    logic                       sck_rise;
    logic                       active;
    logic                       unlocked;
    logic [ADDR_W-1:0]          rd_addr;
    logic [BYTE_W-1:0]          rd_data;
    logic                       wr_stb;
    logic [ADDR_W-1:0]          wr_addr;
    logic [BYTE_W-1:0]          wr_data;
    logic [NUM_CH-1:0]          tbl_we;
    logic [IDX_W-1:0]           tbl_idx;
    logic [BYTE_W-1:0]          tbl_wdata;
    logic [NUM_CH-1:0][BYTE_W-1:0] tbl_rd;
    logic [NUM_CH-1:0][BYTE_W-1:0] pix_in;
    logic [NUM_CH-1:0][BYTE_W-1:0] pix_out;

    assign active = !cs_n_s && pwr_on && pclk_quiet;
    assign pix_in = {pix_b, pix_g, pix_r};
    assign out_r  = pix_out[0];
    assign out_g  = pix_out[1];
    assign out_b  = pix_out[2];

    spi_lut_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_raw (spi_cs_n),
        .sck_raw  (spi_sck),
        .sdi_raw  (spi_sdi),
        .cs_n_s   (cs_n_s),
        .sdi_s    (sdi_s),
        .sck_rise (sck_rise)
    );

    spi_lut_decoder u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .sck_rise (sck_rise),
        .sdi      (sdi_s),
        .unlocked (unlocked),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sdo      (spi_sdo),
        .sdo_en   (spi_sdo_en)
    );

    spi_lut_regs u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwr_on        (pwr_on),
        .wr_stb        (wr_stb),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .rd_addr       (rd_addr),
        .tbl_rd        (tbl_rd),
        .rd_data       (rd_data),
        .unlocked      (unlocked),
        .tbl_we        (tbl_we),
        .tbl_idx       (tbl_idx),
        .tbl_wdata     (tbl_wdata),
        .cfg_lut_en    (cfg_lut_en),
        .cfg_dither_en (cfg_dither_en),
        .cfg_lane3     (cfg_lane3)
    );

    spi_lut_tables u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (tbl_we),
        .idx     (tbl_idx),
        .wdata   (tbl_wdata),
        .spi_rd  (tbl_rd),
        .lut_en  (cfg_lut_en),
        .pix_vld (pix_vld),
        .pix_in  (pix_in),
        .out_vld (out_vld),
        .pix_out (pix_out)
    );
endmodule

// File: rtl/spi_lut_port_chk.sv
// Property checker for spi_lut_port, attached with bind below. Assumes
// the bound signals carry the names of the top level.
module spi_lut_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_on,
    input logic       pclk_quiet,
    input logic       pix_vld,
    input logic [7:0] pix_r,
    input logic       spi_sdo_en,
    input logic       out_vld,
    input logic [7:0] out_r,
    input logic       cfg_lut_en,
    input logic       cfg_dither_en,
    input logic       cfg_lane3,
    input logic       unlocked,
    input logic       spec_open
);
    // R2
    locked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |-> !spi_sdo_en);

    // R5
    lane_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_lane3) |-> $past(spec_open));

    // R10
    quiet_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pclk_quiet |=> !spi_sdo_en);

    // R11
    pwr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> (!cfg_lut_en && !cfg_dither_en && !cfg_lane3 && !unlocked && !spi_sdo_en));

    // R12
    out_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld == $past(pix_vld));

    // R12
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld && !cfg_lut_en) |=> (out_r == $past(pix_r)));
endmodule

bind spi_lut_port spi_lut_port_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_on        (pwr_on),
    .pclk_quiet    (pclk_quiet),
    .pix_vld       (pix_vld),
    .pix_r         (pix_r),
    .spi_sdo_en    (spi_sdo_en),
    .out_vld       (out_vld),
    .out_r         (out_r),
    .cfg_lut_en    (cfg_lut_en),
    .cfg_dither_en (cfg_dither_en),
    .cfg_lane3     (cfg_lane3),
    .unlocked      (unlocked),
    .spec_open     (u_regs.ctrl_q[4])
);

// File: tb/spi_lut_port_tb.sv
// Self-checking bench: serial register traffic, full table sweeps and a
// write/lookup collision, with expectations built from the requirements.
module spi_lut_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 4;
    localparam int WDOG_CYC   = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_on = 1'b1;
    logic pclk_quiet = 1'b1;
    logic spi_cs_n = 1'b1;
    logic spi_sck = 1'b0;
    logic spi_sdi = 1'b0;
    logic spi_sdo, spi_sdo_en;
    logic pix_vld = 1'b0;
    logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0;
    logic out_vld;
    logic [7:0] out_r, out_g, out_b;
    logic cfg_lut_en, cfg_dither_en, cfg_lane3;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    logic [7:0] exp_r [256];
    logic [7:0] exp_g [256];
    logic [7:0] exp_b [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_lut_port u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .pclk_quiet(pclk_quiet),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_sdi(spi_sdi),
        .spi_sdo(spi_sdo), .spi_sdo_en(spi_sdo_en),
        .pix_vld(pix_vld), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .out_vld(out_vld), .out_r(out_r), .out_g(out_g), .out_b(out_b),
        .cfg_lut_en(cfg_lut_en), .cfg_dither_en(cfg_dither_en), .cfg_lane3(cfg_lane3)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] gen(input int kind, input int i);
        if (i >= 256) return 8'hEE;
        case (kind)
            0: return 8'(i * 7 + 3);
            1: return ~8'(i);
            2: return 8'(i) ^ 8'h5A;
            default: return 8'(8'hC0 + i);
        endcase
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_begin();
        @(negedge clk);
        spi_sck  = 1'b0;
        spi_cs_n = 1'b0;
        wait_clk(HALF_SCK);
    endtask

    task automatic spi_end();
        @(negedge clk);
        spi_sck = 1'b0;
        wait_clk(HALF_SCK);
        spi_cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic spi_bit(input logic b);
        @(negedge clk);
        spi_sck = 1'b0;
        spi_sdi = b;
        wait_clk(HALF_SCK);
        spi_sck = 1'b1;
        wait_clk(HALF_SCK);
    endtask

    task automatic spi_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) spi_bit(v[i]);
    endtask

    task automatic reg_wr(input logic [6:0] a, input logic [7:0] d);
        spi_begin();
        spi_byte({1'b0, a});
        spi_byte(d);
        spi_end();
    endtask

    task automatic reg_rd(input logic [6:0] a, output logic [7:0] d, output bit drove);
        d = '0;
        drove = 1'b0;
        spi_begin();
        spi_byte({1'b1, a});
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            spi_sck = 1'b0;
            wait_clk(HALF_SCK);
            d = {d[6:0], spi_sdo};
            if (spi_sdo_en) drove = 1'b1;
            spi_sck = 1'b1;
            wait_clk(HALF_SCK);
        end
        spi_end();
    endtask

    task automatic page_wr(input logic [6:0] a, input int kind, input int n);
        spi_begin();
        spi_byte({1'b0, a});
        for (int i = 0; i < n; i++) spi_byte(gen(kind, i));
        spi_end();
    endtask

    task automatic pixel(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                         output logic [7:0] orr, output logic [7:0] og, output logic [7:0] ob,
                         output logic ov);
        @(negedge clk);
        pix_vld = 1'b1; pix_r = r; pix_g = g; pix_b = b;
        @(negedge clk);
        pix_vld = 1'b0;
        orr = out_r; og = out_g; ob = out_b; ov = out_vld;
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", WDOG_CYC, 0);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, orr, og, ob;
        logic ov;
        bit drove;
        logic [7:0] seen, oldv, newv;
        bit bad, regress, got_new, wr_done;

        wait_clk(5);
        // R14: defaults right after reset
        chk("R14 cfg", {cfg_lut_en, cfg_dither_en, cfg_lane3}, 0);
        chk("R14 sdo_en", spi_sdo_en, 0);
        chk("R14 out_vld", out_vld, 0);
        rst_n = 1'b1;
        wait_clk(3);
        chk("R14 cfg after release", {cfg_lut_en, cfg_dither_en, cfg_lane3}, 0);

        // R2: locked port ignores writes and does not drive reads
        reg_wr(7'h00, 8'h11);
        chk("R2 locked write", cfg_lut_en, 0);
        reg_rd(7'h00, d, drove);
        chk("R2 locked read drive", drove, 0);

        // R2 unlock, R4 control bits and reserved bits
        reg_wr(7'h16, 8'hFF);
        reg_wr(7'h00, 8'hFF);
        chk("R4 lut_en", cfg_lut_en, 1);
        chk("R4 dither", cfg_dither_en, 1);
        reg_rd(7'h00, d, drove);
        chk("R4 ctrl readback", d, 8'h13);
        chk("R3 read drives", drove, 1);
        chk("R3 released", spi_sdo_en, 0);
        // R6: lock register reads zero
        reg_rd(7'h16, d, drove);
        chk("R6 lock read", d, 0);

        // R5: lane register gated by control bit 4
        reg_wr(7'h00, 8'h03);
        reg_wr(7'h0A, 8'h04);
        chk("R5 gated lane", cfg_lane3, 0);
        reg_wr(7'h00, 8'h11);
        reg_wr(7'h0A, 8'hFF);
        chk("R5 lane3", cfg_lane3, 1);
        reg_rd(7'h0A, d, drove);
        chk("R5 lane readback", d, 8'h04);

        // R1: bit order on an asymmetric value
        reg_wr(7'h20, 8'hA5);
        reg_rd(7'h20, d, drove);
        chk("R1 bit order", d, 8'hA5);

        // R8: register-space page write steps to the next address
        spi_begin();
        spi_byte({1'b0, 7'h1F});
        spi_byte(8'hAA);
        spi_byte(8'h5C);
        spi_end();
        reg_rd(7'h20, d, drove);
        chk("R8 register stream", d, 8'h5C);

        // R7/R8: fill red, 257th byte ignored
        reg_wr(7'h20, 8'h00);
        page_wr(7'h40, 0, 257);
        for (int i = 0; i < 256; i++) exp_r[i] = gen(0, i);
        reg_rd(7'h20, d, drove);
        chk("R8 page limit index", d, 8'h00);
        // green from 0x80 with wrap
        reg_wr(7'h20, 8'h80);
        page_wr(7'h41, 1, 256);
        for (int i = 0; i < 256; i++) exp_g[(i + 128) % 256] = gen(1, i);
        // blue full, then a wrapping partial page
        reg_wr(7'h20, 8'h00);
        page_wr(7'h42, 2, 256);
        for (int i = 0; i < 256; i++) exp_b[i] = gen(2, i);
        reg_wr(7'h20, 8'hF0);
        page_wr(7'h42, 3, 32);
        for (int i = 0; i < 32; i++) exp_b[(i + 240) % 256] = gen(3, i);
        reg_rd(7'h20, d, drove);
        chk("R7 index wrap", d, 8'h10);

        // R7: window reads at the index
        reg_wr(7'h20, 8'h05);
        reg_rd(7'h40, d, drove);
        chk("R7 red window read", d, exp_r[5]);
        reg_rd(7'h41, d, drove);
        chk("R7 green window read", d, exp_g[5]);

        // R12: exhaustive table sweep
        for (int v = 0; v < 256; v++) begin
            pixel(8'(v), 8'(255 - v), 8'(v) ^ 8'h33, orr, og, ob, ov);
            chk("R12 red map", orr, exp_r[v]);
            chk("R12 green map", og, exp_g[255 - v]);
            chk("R12 blue map", ob, exp_b[v ^ 8'h33]);
            chk("R12 valid", ov, 1);
        end

        // R12 pass-through and R7 access disabled
        reg_wr(7'h00, 8'h10);
        for (int v = 0; v < 256; v += 17) begin
            pixel(8'(v), 8'(v + 1), 8'(v + 2), orr, og, ob, ov);
            chk("R12 pass", {orr, og, ob}, {8'(v), 8'(v + 1), 8'(v + 2)});
        end
        reg_rd(7'h40, d, drove);
        chk("R7 disabled read", d, 0);
        reg_wr(7'h40, 8'h77);
        reg_wr(7'h00, 8'h11);
        reg_rd(7'h20, d, drove);
        chk("R7 disabled write index", d, 8'h05);
        reg_rd(7'h40, d, drove);
        chk("R7 disabled write entry", d, exp_r[5]);

        // R9: abort in mid data byte, then in mid header
        spi_begin();
        spi_byte({1'b0, 7'h20});
        for (int i = 0; i < 4; i++) spi_bit(1'b1);
        spi_end();
        reg_rd(7'h20, d, drove);
        chk("R9 data abort", d, 8'h05);
        spi_begin();
        for (int i = 0; i < 3; i++) spi_bit(1'b1);
        spi_end();
        reg_wr(7'h20, 8'h09);
        reg_rd(7'h20, d, drove);
        chk("R9 header abort", d, 8'h09);

        // R10: pixel clock not static blocks the port
        pclk_quiet = 1'b0;
        reg_wr(7'h20, 8'h44);
        pclk_quiet = 1'b1;
        wait_clk(2);
        reg_rd(7'h20, d, drove);
        chk("R10 gated", d, 8'h09);

        // R13: serial write and lookup of the same entry
        reg_wr(7'h20, 8'h10);
        oldv = exp_r[16];
        newv = 8'h99;
        @(negedge clk);
        pix_vld = 1'b1; pix_r = 8'h10; pix_g = 8'h00; pix_b = 8'h00;
        wait_clk(2);
        bad = 1'b0; regress = 1'b0; got_new = 1'b0; wr_done = 1'b0;
        fork
            begin
                reg_wr(7'h40, newv);
                wr_done = 1'b1;
            end
            begin
                while (!wr_done) begin
                    @(negedge clk);
                    seen = out_r;
                    if (seen != oldv && seen != newv) bad = 1'b1;
                    if (seen == newv) got_new = 1'b1;
                    if (got_new && seen == oldv) regress = 1'b1;
                end
            end
        join
        wait_clk(2);
        seen = out_r;
        pix_vld = 1'b0;
        exp_r[16] = newv;
        chk("R13 only old or new", bad, 0);
        chk("R13 no return to old", regress, 0);
        chk("R13 final new", seen, newv);

        // R11: power-down clears registers, keeps tables
        @(negedge clk);
        pwr_on = 1'b0;
        wait_clk(2);
        chk("R11 cfg cleared", {cfg_lut_en, cfg_dither_en, cfg_lane3}, 0);
        pwr_on = 1'b1;
        wait_clk(2);
        reg_rd(7'h00, d, drove);
        chk("R11 relocked", drove, 0);
        reg_wr(7'h16, 8'hFF);
        reg_wr(7'h00, 8'h01);
        pixel(8'h10, 8'h00, 8'h00, orr, og, ob, ov);
        chk("R11 red kept", orr, exp_r[16]);
        pixel(8'hF5, 8'h7F, 8'hF3, orr, og, ob, ov);
        chk("R11 tables kept", {orr, og, ob}, {exp_r[245], exp_g[127], exp_b[243]});

        // R2: relock with a non-key value
        reg_wr(7'h16, 8'h00);
        reg_wr(7'h00, 8'h00);
        chk("R2 relock ignores", cfg_lut_en, 1);
        reg_rd(7'h00, d, drove);
        chk("R2 relock no drive", drove, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule